// File: doc/BRIEF.md
# Card Clock Divider with Bypass

This block derives the clock that drives an SD/MMC card from the host's master clock. Software loads one 16-bit control word. The word holds an 8-bit divider value, a run bit, a bypass bit and a flow-control enable bit. A parameter fixed at elaboration picks the divide law. The offset law makes a period of divider+2 master cycles. The even law makes a period of 2×(divider+1) master cycles with equal high and low phases.

In bypass the card clock is the master clock, gated on its low phase. With flow control enabled, a stall from the data FIFO parks the divided clock low at the end of its current period. The clock then resumes with a full high phase once the stall clears. A newly written divider value is picked up only when the running period finishes, so no pulse is ever shortened by a reprogram.

Top module: `cardclk_gen`

## Requirements
- R1: After reset, and whenever the run bit (control word bit 8) is clear, the card clock stays low.
- R2: With EVEN_MODE=0 and divider N (word bits 7:0), the card clock period is N+2 master cycles. The high phase is floor((N+2)/2) cycles and the low phase takes the rest.
- R3: With EVEN_MODE=1 and divider N, the period is 2×(N+1) master cycles, with N+1 high and N+1 low.
- R4: With the run bit and the bypass bit (word bit 9) both set, the card clock is high while the master clock is high and low while it is low.
- R5: With the flow-control bit (word bit FC_BIT, default 13) set and fifoStall high, the divided clock finishes its period and then holds low. After fifoStall falls it restarts with a full-length high phase.
- R6: With the flow-control bit clear, fifoStall has no effect on the divided clock. This includes a word that sets the other candidate bit position (bit 14 when FC_BIT is 13).
- R7: A divider written during a period takes effect only at the start of the next period. The current high and low phases keep their old lengths.
- R8: In bypass with flow control set, a high fifoStall gates the card clock low.
- R9: While bypass is selected, the divided path is parked low and produces no rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 16 | Control word: divider, run, bypass, flow-control enable |
| fifoStall | input | 1 | FIFO cannot proceed; honoured only with flow control set |
| cardClk | output | 1 | Card clock |

## Verification
On every cycle the assertions check that the divided path is low when the run bit is clear or bypass is selected. They also check that a stalled, low clock under flow control cannot rise, and that a rising edge only follows a running, non-bypassed state. Phase lengths for each divide law and the boundary at which a new divider applies can only be shown by the bench. The same goes for the master-clock copy in bypass and the full high phase after a stall ends. The bench measures these run by run on two instances, one per divide law.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // park counter idle, output low
    logic advance;  // step counter one master cycle
  } clkStrobes_t;
endpackage

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
  import cardclk_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int WORD_W  = 16,
  parameter int EN_BIT  = 8,
  parameter int BYP_BIT = 9,
  parameter int FC_BIT  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              fifoStall,
  input  logic              atEnd,
  output logic [DIV_W-1:0]  divVal,
  output logic              enQ,
  output logic              bypQ,
  output logic              fcQ,
  output logic              bypGateReq,
  output clkStrobes_t       strobes
);
  logic holdReq;
  logic unusedWr;
  assign unusedWr = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal <= '0;
      enQ    <= 1'b0;
      bypQ   <= 1'b0;
      fcQ    <= 1'b0;
    end else if (wrEn) begin
      divVal <= wrData[DIV_W-1:0];
      enQ    <= wrData[EN_BIT];
      bypQ   <= wrData[BYP_BIT];
      fcQ    <= wrData[FC_BIT];
    end
  end

  always_comb begin
    holdReq         = fcQ && fifoStall;
    strobes.restart = !enQ || bypQ;
    // a stall freezes the counter only on the last low cycle of a period
    strobes.advance = enQ && !bypQ && !(holdReq && atEnd);
    bypGateReq      = enQ && bypQ && !holdReq;
  end
endmodule

// File: rtl/cardclk_dp.sv
module cardclk_dp
  import cardclk_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter bit EVEN_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divVal,
  input  clkStrobes_t      strobes,
  input  logic             bypSel,
  input  logic             bypGateReq,
  output logic             atEnd,
  output logic             divOut,
  output logic             cardClk
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] lastCur;
  logic [CNT_W-1:0] highTopNext;
  logic [DIV_W-1:0] activeDiv;
  logic [DIV_W-1:0] nextDiv;
  logic             idle;
  logic             bypGate;

  assign atEnd   = idle || (cnt == lastCur);
  assign nextDiv = atEnd ? divVal : activeDiv;
  assign nextCnt = atEnd ? '0 : cnt + 1'b1;

  generate
    if (EVEN_MODE) begin : g_even
      // period 2*(d+1): last index 2d+1, high while cnt <= d
      assign lastCur     = {activeDiv, 1'b1};
      assign highTopNext = {1'b0, nextDiv};
    end else begin : g_offset
      // period d+2: last index d+1, high while cnt <= d/2
      assign lastCur     = {1'b0, activeDiv} + 1'b1;
      assign highTopNext = {1'b0, nextDiv >> 1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      idle      <= 1'b1;
      activeDiv <= '0;
      divOut    <= 1'b0;
    end else if (strobes.restart) begin
      cnt    <= '0;
      idle   <= 1'b1;
      divOut <= 1'b0;
    end else if (strobes.advance) begin
      idle      <= 1'b0;
      cnt       <= nextCnt;
      activeDiv <= nextDiv;
      divOut    <= (nextCnt <= highTopNext);
    end
  end

  // gate for the bypass path changes only while the master clock is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) bypGate <= 1'b0;
    else       bypGate <= bypGateReq;
  end

  assign cardClk = bypSel ? (clk & bypGate) : divOut;
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cardclk_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int WORD_W    = 16,
  parameter int FC_BIT    = 13,
  parameter bit EVEN_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              fifoStall,
  output logic              cardClk
);
  localparam int EN_BIT  = DIV_W;
  localparam int BYP_BIT = DIV_W + 1;

  clkStrobes_t      strobes;
  logic [DIV_W-1:0] divVal;
  logic             enQ;
  logic             bypQ;
  logic             fcQ;
  logic             bypGateReq;
  logic             atEnd;
  logic             divOut;

  cardclk_ctrl #(
    .DIV_W(DIV_W), .WORD_W(WORD_W), .EN_BIT(EN_BIT),
    .BYP_BIT(BYP_BIT), .FC_BIT(FC_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .fifoStall(fifoStall), .atEnd(atEnd), .divVal(divVal),
    .enQ(enQ), .bypQ(bypQ), .fcQ(fcQ), .bypGateReq(bypGateReq),
    .strobes(strobes)
  );

  cardclk_dp #(
    .DIV_W(DIV_W), .EVEN_MODE(EVEN_MODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .divVal(divVal), .strobes(strobes),
    .bypSel(bypQ), .bypGateReq(bypGateReq), .atEnd(atEnd),
    .divOut(divOut), .cardClk(cardClk)
  );
endmodule

// File: rtl/cardclk_chk.sv
module cardclk_chk (
  input logic clk,
  input logic rstN,
  input logic enQ,
  input logic bypQ,
  input logic fcQ,
  input logic fifoStall,
  input logic divOut
);
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |=> !divOut);

  assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fcQ && fifoStall && enQ && !bypQ && !divOut) |=> !divOut);

  assert_bypass_parks_R9: assert property (@(posedge clk) disable iff (!rstN)
    bypQ |=> !divOut);

  assert_rise_when_running_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divOut) |-> $past(enQ && !bypQ));
endmodule

bind cardclk_gen cardclk_chk u_chk (
  .clk(clk), .rstN(rstN), .enQ(enQ), .bypQ(bypQ),
  .fcQ(fcQ), .fifoStall(fifoStall), .divOut(divOut)
);

// File: tb/sim_cardclk_gen.sv
module sim_cardclk_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        fifoStall = 1'b0;
  logic        cardClk0;
  logic        cardClk1;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  localparam logic [15:0] RUN  = 16'h0100;
  localparam logic [15:0] BYP  = 16'h0200;
  localparam logic [15:0] FC   = 16'h2000;
  localparam logic [15:0] FC14 = 16'h4000;

  // divider, offset high, offset low, even high, even low
  localparam int VEC [5][5] = '{
    '{0,   1,   1,   1,   1},
    '{1,   1,   2,   2,   2},
    '{3,   2,   3,   4,   4},
    '{6,   4,   4,   7,   7},
    '{255, 128, 129, 256, 256}
  };

  always #4 clk = ~clk;

  cardclk_gen #(.EVEN_MODE(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .fifoStall(fifoStall), .cardClk(cardClk0));

  cardclk_gen #(.EVEN_MODE(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .fifoStall(fifoStall), .cardClk(cardClk1));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeCtl(input logic [15:0] w);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic pick(input bit which);
    return which ? cardClk1 : cardClk0;
  endfunction

  task automatic measure(input bit which, output int hi, output int lo);
    int g;
    g = 0;
    do begin @(negedge clk); g++; end while (pick(which) != 1'b0 && g < 2000);
    do begin @(negedge clk); g++; end while (pick(which) != 1'b1 && g < 4000);
    hi = 0;
    while (pick(which) == 1'b1 && hi < 2000) begin hi++; @(negedge clk); end
    lo = 0;
    while (pick(which) == 1'b0 && lo < 2000) begin lo++; @(negedge clk); end
  endtask

  task automatic countHigh(input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (cardClk0 || cardClk1) h++;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi, lo, hi2, lo2, h;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 low in reset", int'(cardClk0 | cardClk1), 0);
    rstN = 1'b1;
    countHigh(10, h);
    check("R1 low after reset", h, 0);

    // R2 / R3: table of divider values
    for (int i = 0; i < 5; i++) begin
      writeCtl(RUN | 16'(VEC[i][0]));
      measure(1'b0, hi, lo);
      check($sformatf("R2 offset high N=%0d", VEC[i][0]), hi, VEC[i][1]);
      check($sformatf("R2 offset low N=%0d", VEC[i][0]), lo, VEC[i][2]);
      measure(1'b1, hi, lo);
      check($sformatf("R3 even high N=%0d", VEC[i][0]), hi, VEC[i][3]);
      check($sformatf("R3 even low N=%0d", VEC[i][0]), lo, VEC[i][4]);
    end

    // R7: divider change mid-period applies at the next period
    writeCtl(RUN | 16'd6);
    do @(negedge clk); while (cardClk0 != 1'b0);
    do @(negedge clk); while (cardClk0 != 1'b1);
    wrEn = 1'b1;
    wrData = RUN | 16'd0;
    hi = 1;
    @(negedge clk);
    wrEn = 1'b0;
    while (cardClk0 == 1'b1 && hi < 100) begin hi++; @(negedge clk); end
    lo = 0;
    while (cardClk0 == 1'b0 && lo < 100) begin lo++; @(negedge clk); end
    hi2 = 0;
    while (cardClk0 == 1'b1 && hi2 < 100) begin hi2++; @(negedge clk); end
    lo2 = 0;
    while (cardClk0 == 1'b0 && lo2 < 100) begin lo2++; @(negedge clk); end
    check("R7 old high kept", hi, 4);
    check("R7 old low kept", lo, 4);
    check("R7 new high", hi2, 1);
    check("R7 new low", lo2, 1);

    // R5: stall with flow control holds low, then full high phase
    writeCtl(RUN | FC | 16'd3);
    repeat (7) @(negedge clk);
    fifoStall = 1'b1;
    repeat (12) @(negedge clk);
    countHigh(20, h);
    check("R5 held low under stall", h, 0);
    fifoStall = 1'b0;
    hi = 0;
    do @(negedge clk); while (cardClk0 != 1'b1);
    while (cardClk0 == 1'b1 && hi < 100) begin hi++; @(negedge clk); end
    check("R5 full high after release", hi, 2);

    // R6: stall ignored with flow control clear
    writeCtl(RUN | 16'd3);
    fifoStall = 1'b1;
    measure(1'b0, hi, lo);
    check("R6 stall ignored high", hi, 2);
    check("R6 stall ignored low", lo, 3);
    writeCtl(RUN | FC14 | 16'd3);
    measure(1'b1, hi, lo);
    check("R6 bit 14 no effect even high", hi, 4);
    measure(1'b0, hi, lo);
    check("R6 bit 14 no effect offset low", lo, 3);
    fifoStall = 1'b0;

    // R4: bypass follows master clock
    writeCtl(RUN | BYP | 16'd5);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check("R4 bypass high phase", int'(cardClk0 & cardClk1), 1);
      @(negedge clk); #1;
      check("R4 bypass low phase", int'(cardClk0 | cardClk1), 0);
    end

    // R8: bypass gated by stall under flow control
    writeCtl(RUN | BYP | FC | 16'd5);
    fifoStall = 1'b1;
    repeat (2) @(negedge clk);
    @(posedge clk); #1;
    check("R8 bypass gated by stall", int'(cardClk0 | cardClk1), 0);
    fifoStall = 1'b0;
    repeat (2) @(negedge clk);
    @(posedge clk); #1;
    check("R8 bypass resumes", int'(cardClk0 & cardClk1), 1);

    // R1: run bit cleared while dividing
    writeCtl(RUN | 16'd2);
    repeat (10) @(negedge clk);
    writeCtl(16'd2);
    countHigh(20, h);
    check("R1 low when run clear", h, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule